// File: doc/BRIEF.md
# Packed-to-Chunky Pixel Expander

This block is a one-way copy engine. It fetches packed source bytes from a main-memory read port and writes unpacked pixels to a separate framebuffer write port. Each output pixel is one byte holding a colour index. There is no path in the other direction. Software sets up the following before a job:

- the source and destination base addresses,
- the rectangle width and height in pixels,
- the destination row pitch,
- a format selector and three palette inputs.

A one-cycle `start` pulse then launches the job. The engine copies the whole configuration at `start`, so the inputs may change while a job runs.

There are four source packings:

- one bit per pixel (8 pixels per byte, 2 colours),
- two bits per pixel (4 pixels per byte, 4 colours),
- a three-pixel packing (3 pixels per byte, 4 colours picked from one of 4 per-byte colour sets),
- four bits per pixel (2 pixels per byte, 16 colours).

There are no bit planes, raster operations, barrel shifts or multiple sources. Both memory ports are plain request/ready interfaces. Read data arrives one cycle after the request is accepted.

Top module: `pixel_expander`

## Requirements
- R1: After reset, `busy`, `done`, `rd_req` and `wr_req` are low. A `start` pulse with nonzero width and height raises `busy` on the next cycle. A `start` or configuration change while `busy` is high has no effect on the running job, and no second job follows it.
- R2: With `fmt`=0, each source byte gives 8 pixels, most significant bit first. A 0 bit writes `pal_mono[7:0]` and a 1 bit writes `pal_mono[15:8]`.
- R3: With `fmt`=1, each byte gives 4 two-bit indices, starting with bits [7:6]. Index k writes `pal_quad[8k+7:8k]`.
- R4: With `fmt`=2, bits [7:6] of a byte select colour set s. The byte's three pixels use indices from bits [5:4], then [3:2], then [1:0]. Index k writes the zero-extended 4-bit value `pal_micro[16s+4k+3:16s+4k]`.
- R5: With `fmt`=3, each byte gives 2 pixels: the high nibble first, then the low nibble. Each is zero-extended to 8 bits.
- R6: When the width is not a multiple of the pixels per byte, the unused pixels of a row's last byte are dropped and the next row begins with a new source byte. A job therefore reads exactly height × ceil(width / pixels-per-byte) consecutive bytes from `src_base`.
- R7: Pixel (row r, column c) is written once, to `dst_base + r*stride + c`. No other address is written.
- R8: A request that is not accepted keeps its address (and write data) unchanged on the next cycle. Read data is taken from `rd_data` one cycle after `rd_req && rd_ready`.
- R9: `done` pulses for exactly one cycle, in the cycle after the last pixel write is accepted. `busy` is low in that cycle.
- R10: A `start` with zero width or zero height makes no memory access, pulses `done` on the next cycle and never raises `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch pulse, sampled only when idle |
| fmt | input | 2 | Source packing: 0 one-bit, 1 two-bit, 2 three-pixel, 3 four-bit |
| src_base | input | AW | First source byte address |
| dst_base | input | AW | Address of the top-left destination pixel |
| width | input | CW | Pixels per row |
| height | input | CW | Number of rows |
| stride | input | AW | Destination address step between rows |
| pal_mono | input | 16 | Two 8-bit colours for the one-bit format |
| pal_quad | input | 32 | Four 8-bit colours for the two-bit format |
| pal_micro | input | 64 | Four colour sets of four 4-bit indices |
| rd_req | output | 1 | Source read request |
| rd_addr | output | AW | Source read address |
| rd_ready | input | 1 | Source port accepts the request |
| rd_data | input | 8 | Source byte, valid one cycle after acceptance |
| wr_req | output | 1 | Framebuffer write request |
| wr_addr | output | AW | Framebuffer write address |
| wr_data | output | 8 | Pixel value |
| wr_ready | input | 1 | Framebuffer accepts the write |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The test jobs cover all four packings, and each source byte comes from a position-dependent pattern. A wrong bit order or wrong palette slot therefore shows up as a wrong pixel value. Some widths leave part of the last byte unused (5 one-bit pixels, 4 three-pixel pixels, 1 two-bit pixel, 3 four-bit pixels). These jobs separate a design that restarts each row on a new byte from one that carries leftover pixels into the next row, and the read count confirms which. Row pitches wider than, equal to and less than the width, along with stalls on either port, check that addressing and data hold under back-pressure. Zero-size jobs and a second `start` during a job check the launch rules.

// File: rtl/pixel_expander.sv
module pixel_expander #(
  parameter int AW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    fmt,
  input  logic [AW-1:0] src_base,
  input  logic [AW-1:0] dst_base,
  input  logic [CW-1:0] width,
  input  logic [CW-1:0] height,
  input  logic [AW-1:0] stride,
  input  logic [15:0]   pal_mono,
  input  logic [31:0]   pal_quad,
  input  logic [63:0]   pal_micro,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_ready,
  input  logic [7:0]    rd_data,
  output logic          wr_req,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  input  logic          wr_ready,
  output logic          busy,
  output logic          done
);

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_LOAD, S_EMIT} state_t;
  state_t state;

  logic [1:0]    fmt_q;
  logic [CW-1:0] w_q, h_q, col, row;
  logic [AW-1:0] stride_q, src_ptr, dst_row;
  logic [15:0]   mono_q;
  logic [31:0]   quad_q;
  logic [63:0]   micro_q;
  logic [7:0]    byte_q;
  logic [2:0]    pix, pix_last;
  logic [3:0]    shamt;
  logic [7:0]    shifted;
  logic [1:0]    qidx, set_sel;
  logic [7:0]    colour;

  assign busy    = state != S_IDLE;
  assign rd_req  = state == S_FETCH;
  assign rd_addr = src_ptr;
  assign wr_req  = state == S_EMIT;
  assign wr_addr = dst_row + AW'(col);
  assign wr_data = colour;

  always_comb begin
    case (fmt_q)
      2'd0:    begin pix_last = 3'd7; shamt = {1'b0, pix};        end
      2'd1:    begin pix_last = 3'd3; shamt = {pix, 1'b0};        end
      2'd2:    begin pix_last = 3'd2; shamt = {pix, 1'b0};        end
      default: begin pix_last = 3'd1; shamt = {1'b0, pix[0], 2'b00}; end
    endcase
  end

  assign shifted = byte_q << shamt;
  assign set_sel = byte_q[7:6];
  assign qidx    = (fmt_q == 2'd2) ? shifted[5:4] : shifted[7:6];

  always_comb begin
    case (fmt_q)
      2'd0:    colour = shifted[7] ? mono_q[15:8] : mono_q[7:0];
      2'd1:    colour = quad_q[{qidx, 3'b000} +: 8];
      2'd2:    colour = {4'h0, micro_q[{set_sel, qidx, 2'b00} +: 4]};
      default: colour = {4'h0, shifted[7:4]};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      done     <= 1'b0;
      fmt_q    <= '0;
      w_q      <= '0;
      h_q      <= '0;
      stride_q <= '0;
      mono_q   <= '0;
      quad_q   <= '0;
      micro_q  <= '0;
      src_ptr  <= '0;
      dst_row  <= '0;
      col      <= '0;
      row      <= '0;
      pix      <= '0;
      byte_q   <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          fmt_q    <= fmt;
          w_q      <= width;
          h_q      <= height;
          stride_q <= stride;
          mono_q   <= pal_mono;
          quad_q   <= pal_quad;
          micro_q  <= pal_micro;
          src_ptr  <= src_base;
          dst_row  <= dst_base;
          col      <= '0;
          row      <= '0;
          pix      <= '0;
          if (width == '0 || height == '0) done <= 1'b1;
          else state <= S_FETCH;
        end
        S_FETCH: if (rd_ready) state <= S_LOAD;
        S_LOAD: begin
          byte_q <= rd_data;
          state  <= S_EMIT;
        end
        S_EMIT: if (wr_ready) begin
          if (col == w_q - 1'b1) begin
            col <= '0;
            pix <= '0;
            if (row == h_q - 1'b1) begin
              state <= S_IDLE;
              done  <= 1'b1;
            end else begin
              row     <= row + 1'b1;
              dst_row <= dst_row + stride_q;
              src_ptr <= src_ptr + 1'b1;
              state   <= S_FETCH;
            end
          end else begin
            col <= col + 1'b1;
            if (pix == pix_last) begin
              pix     <= '0;
              src_ptr <= src_ptr + 1'b1;
              state   <= S_FETCH;
            end else begin
              pix <= pix + 1'b1;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pixel_expander_chk.sv
module pixel_expander_chk #(
  parameter int AW = 16,
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [CW-1:0] width,
  input logic [CW-1:0] height,
  input logic          rd_req,
  input logic [AW-1:0] rd_addr,
  input logic          rd_ready,
  input logic          wr_req,
  input logic [AW-1:0] wr_addr,
  input logic [7:0]    wr_data,
  input logic          wr_ready,
  input logic          busy,
  input logic          done
);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rd_req && !wr_req);

  assert_launch_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  assert_rd_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_ready |=> rd_req && $stable(rd_addr));

  assert_wr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && !wr_ready |=> wr_req && $stable(wr_addr) && $stable(wr_data));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_empty_job_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && (width == '0 || height == '0) |=> done && !busy);

endmodule

bind pixel_expander pixel_expander_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .width(width), .height(height),
  .rd_req(rd_req), .rd_addr(rd_addr), .rd_ready(rd_ready),
  .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready),
  .busy(busy), .done(done)
);

// File: tb/sim_pixel_expander.sv
module sim_pixel_expander;
  localparam int AW = 16;
  localparam int CW = 8;
  localparam logic [15:0] PMONO  = 16'hA53C;
  localparam logic [31:0] PQUAD  = 32'h1122_3344;
  localparam logic [63:0] PMICRO = 64'h0123_4567_89AB_CDEF;

  typedef struct packed {
    logic [1:0] fmt;
    logic [1:0] rdy;
    logic [7:0] w, h, stride, src, dst;
  } vec_t;

  localparam vec_t VEC [0:7] = '{
    '{2'd0, 2'd0, 8'd16, 8'd2, 8'd20, 8'd0,   8'd0},
    '{2'd1, 2'd1, 8'd8,  8'd3, 8'd10, 8'd10,  8'd4},
    '{2'd2, 2'd2, 8'd9,  8'd2, 8'd12, 8'd30,  8'd8},
    '{2'd3, 2'd3, 8'd6,  8'd3, 8'd8,  8'd50,  8'd0},
    '{2'd0, 2'd0, 8'd5,  8'd2, 8'd7,  8'd70,  8'd3},
    '{2'd2, 2'd3, 8'd4,  8'd3, 8'd5,  8'd90,  8'd2},
    '{2'd1, 2'd0, 8'd1,  8'd4, 8'd1,  8'd100, 8'd40},
    '{2'd3, 2'd1, 8'd3,  8'd1, 8'd0,  8'd120, 8'd9}
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n, start;
  logic [1:0]    fmt;
  logic [AW-1:0] src_base, dst_base, stride;
  logic [CW-1:0] width, height;
  logic          rd_req, rd_ready, wr_req, wr_ready, busy, done;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [7:0]    rd_data, wr_data;
  logic [1:0]    rdy_mode;
  logic [7:0]    tick;
  logic          fb_clr;
  logic [7:0]    src_mem [0:255];
  logic [7:0]    fb [0:255];
  logic [7:0]    expv [0:255];
  int            rcount, wcount;
  int            tests = 0, fails = 0;

  pixel_expander #(.AW(AW), .CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .fmt(fmt),
    .src_base(src_base), .dst_base(dst_base), .width(width), .height(height),
    .stride(stride), .pal_mono(PMONO), .pal_quad(PQUAD), .pal_micro(PMICRO),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ready(rd_ready), .rd_data(rd_data),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready),
    .busy(busy), .done(done)
  );

  assign rd_ready = rdy_mode[0] ? (tick % 3 != 2) : 1'b1;
  assign wr_ready = rdy_mode[1] ? tick[0] : 1'b1;

  always @(posedge clk) begin
    tick <= tick + 8'd1;
    if (rd_req && rd_ready) rd_data <= src_mem[rd_addr[7:0]];
    if (fb_clr) begin
      for (int i = 0; i < 256; i++) fb[i] <= 8'hEE;
      rcount <= 0;
      wcount <= 0;
    end else begin
      if (rd_req && rd_ready) rcount <= rcount + 1;
      if (wr_req && wr_ready) begin
        fb[wr_addr[7:0]] <= wr_data;
        wcount <= wcount + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int ppb(input logic [1:0] f);
    case (f)
      2'd0: return 8;
      2'd1: return 4;
      2'd2: return 3;
      default: return 2;
    endcase
  endfunction

  function automatic logic [7:0] expect_pix(input logic [1:0] f, input logic [7:0] b, input int i);
    int k, s;
    case (f)
      2'd0: return b[7-i] ? PMONO[15:8] : PMONO[7:0];
      2'd1: begin k = (b >> (6 - 2*i)) & 3; return PQUAD[k*8 +: 8]; end
      2'd2: begin
        s = b[7:6];
        k = (b >> (4 - 2*i)) & 3;
        return {4'h0, PMICRO[s*16 + k*4 +: 4]};
      end
      default: return (i == 0) ? {4'h0, b[7:4]} : {4'h0, b[3:0]};
    endcase
  endfunction

  function automatic string fmt_tag(input logic [1:0] f);
    case (f)
      2'd0: return "R2";
      2'd1: return "R3";
      2'd2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic run_vec(input vec_t v);
    int bpr, bad, first_bad_a, cyc;
    bit timed_out;
    @(negedge clk);
    fb_clr = 1'b1;
    @(negedge clk);
    fb_clr = 1'b0;
    rdy_mode = v.rdy;
    fmt = v.fmt; width = v.w; height = v.h; stride = AW'(v.stride);
    src_base = AW'(v.src); dst_base = AW'(v.dst);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1, "R1", "busy after start", int'(busy), 1);
    @(negedge clk);
    @(negedge clk);
    fmt = ~v.fmt; width = 8'd200; height = 8'd200; src_base = 16'h0080; dst_base = 16'h0090;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    timed_out = 1'b0;
    while (done !== 1'b1) begin
      @(negedge clk);
      cyc++;
      if (cyc > 5000) begin timed_out = 1'b1; break; end
    end
    check(!timed_out, "R9", "done reached", cyc, 0);
    check(busy === 1'b0, "R9", "busy low with done", int'(busy), 0);
    @(negedge clk);
    check(done === 1'b0, "R9", "done one cycle", int'(done), 0);
    @(negedge clk);
    check(busy === 1'b0, "R1", "no second job", int'(busy), 0);
    bpr = (v.w + ppb(v.fmt) - 1) / ppb(v.fmt);
    for (int a = 0; a < 256; a++) expv[a] = 8'hEE;
    for (int r = 0; r < v.h; r++)
      for (int c = 0; c < v.w; c++)
        expv[(v.dst + r*v.stride + c) & 255] =
          expect_pix(v.fmt, src_mem[(v.src + r*bpr + c/ppb(v.fmt)) & 255], c % ppb(v.fmt));
    bad = 0;
    first_bad_a = 0;
    for (int a = 0; a < 256; a++)
      if (fb[a] !== expv[a]) begin
        if (bad == 0) first_bad_a = a;
        bad++;
      end
    check(bad == 0, fmt_tag(v.fmt), "pixel values", int'(fb[first_bad_a]), int'(expv[first_bad_a]));
    check(bad == 0, "R7", "untouched/addressed bytes", bad, 0);
    check(wcount == int'(v.w) * int'(v.h), "R7", "write count", wcount, int'(v.w) * int'(v.h));
    check(rcount == bpr * int'(v.h), "R6", "read count", rcount, bpr * int'(v.h));
  endtask

  task automatic zero_job(input logic [7:0] w, input logic [7:0] h);
    @(negedge clk);
    fb_clr = 1'b1;
    @(negedge clk);
    fb_clr = 1'b0;
    fmt = 2'd0; width = w; height = h;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done === 1'b1, "R10", "done after empty start", int'(done), 1);
    check(busy === 1'b0, "R10", "busy stays low", int'(busy), 0);
    @(negedge clk);
    @(negedge clk);
    check(rcount == 0 && wcount == 0, "R10", "no accesses", rcount + wcount, 0);
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) src_mem[i] = 8'((i * 37 + 11) ^ (i >> 3));
    tick = 8'd0;
    rd_data = 8'd0;
    rdy_mode = 2'd0;
    fb_clr = 1'b0;
    rcount = 0;
    wcount = 0;
    rst_n = 1'b0; start = 1'b0; fmt = 2'd0;
    src_base = '0; dst_base = '0; stride = '0; width = '0; height = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy === 1'b0 && done === 1'b0, "R1", "reset busy/done", int'({busy, done}), 0);
    check(rd_req === 1'b0 && wr_req === 1'b0, "R1", "reset requests", int'({rd_req, wr_req}), 0);

    for (int n = 0; n < 8; n++) run_vec(VEC[n]);

    zero_job(8'd0, 8'd4);
    zero_job(8'd5, 8'd0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule